// File: doc/BRIEF.md
# Idle-State Snoop Controller

This block follows a processor core through its idle power states and lets the core answer bus snoops without leaving idle for good. Halt and stop-grant requests move it out of the running state. A wake or break event brings it back. A snoop-start strobe from the bus interface parks it in a snoop-servicing state, and it stays there until a serviced indication arrives. The snoop may be serviced by this core or by another agent on the bus.

On entry to a snoop the block records the idle state it came from, and it goes back to that state once the snoop ends. When the enhanced-halt enable is set, a halt request leads to an enhanced halt state that asks for the reduced voltage and frequency point. A snoop taken from enhanced halt goes to an enhanced snoop state, which keeps that low operating point for the whole snoop. A wake that arrives while a snoop is in progress is held back and acted on when the snoop completes. Decoding the bus protocol and performing the cache lookup are done outside this block.

Top module: `idle_snoop_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the state output reads running (code 0), and the snoop clock enable and the low operating point request are both low.
- R2: From running, a stop-grant request moves the state to stop-grant (code 3) and wins over a halt request in the same cycle. A halt request alone moves the state to halt (code 1) when the enhanced-halt enable is low, or to enhanced halt (code 2) when it is high.
- R3: A snoop-start strobe in halt or stop-grant moves the state to snoop (code 4). In enhanced halt it moves the state to enhanced snoop (code 5). In the running state it has no effect.
- R4: In either snoop state the state holds for every cycle in which the serviced indication is low.
- R5: When the serviced indication arrives and no wake is owed, the state returns to the idle state recorded at snoop entry: halt, enhanced halt or stop-grant.
- R6: The low operating point request is high exactly in enhanced halt and enhanced snoop.
- R7: The snoop clock enable is high exactly in snoop and enhanced snoop.
- R8: A wake event in halt or enhanced halt returns the state to running on the next cycle. If a snoop-start strobe comes in the same cycle, the snoop takes priority and the wake is owed.
- R9: For a snoop entered from halt or enhanced halt, a wake seen at entry, during the snoop, or together with the serviced indication makes the state go to running when the snoop ends. For a snoop entered from stop-grant, wake events have no effect.
- R10: In stop-grant with neither a stop-grant request nor a snoop-start strobe, the state returns to running on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Request to enter halt |
| stpgnt_req | input | 1 | Stop-grant request, held for as long as stop-grant is wanted |
| ehalt_en | input | 1 | Selects enhanced halt for halt entry |
| wake_evt | input | 1 | Wake or break event |
| snoop_start | input | 1 | Strobe marking the start of a bus snoop |
| snoop_done | input | 1 | The snoop has been serviced by any agent |
| state_o | output | 3 | Current state code (0 to 5) |
| snoop_clk_en | output | 1 | Clock-enable request for the snoop logic |
| low_op_req | output | 1 | Request for the reduced voltage and frequency point |

## Verification
Several properties are checked on every cycle: the snoop states hold while the serviced indication is low, snoop entry from each idle state goes to the matching snoop state, an enhanced snoop exits only to enhanced halt or running, stop-grant falls back to running once its request drops, and the two output requests agree with the state code. Other behaviour can only be shown by the bench's sweep. This covers the return to the correct origin after snoops of several lengths, and a wake that arrives at entry, in the middle of the snoop or on the final cycle and must still be honoured. It also covers wakes that must be ignored after a snoop taken from stop-grant.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN    = 3'd0,
    ST_HALT   = 3'd1,
    ST_EHALT  = 3'd2,
    ST_STPGNT = 3'd3,
    ST_SNOOP  = 3'd4,
    ST_ESNOOP = 3'd5
  } pstate_e;

  function automatic logic is_snoop(pstate_e s);
    return (s == ST_SNOOP) || (s == ST_ESNOOP);
  endfunction

  function automatic logic is_halt(pstate_e s);
    return (s == ST_HALT) || (s == ST_EHALT);
  endfunction
endpackage

// File: rtl/isc_next.sv
module isc_next
  import isc_pkg::*;
(
  input  pstate_e cur,
  input  pstate_e ret_q,
  input  logic    pend_q,
  input  logic    halt_req,
  input  logic    stpgnt_req,
  input  logic    ehalt_en,
  input  logic    wake_evt,
  input  logic    snoop_start,
  input  logic    snoop_done,
  output pstate_e nxt,
  output logic    ret_we,
  output logic    pend_we,
  output logic    pend_d
);
  logic idle_src;
  logic owed;

  assign idle_src = is_halt(cur) || (cur == ST_STPGNT);
  assign owed     = (pend_q || wake_evt) && is_halt(ret_q);

  always_comb begin
    nxt     = cur;
    ret_we  = 1'b0;
    pend_we = 1'b0;
    pend_d  = 1'b0;
    if (idle_src && snoop_start) begin
      nxt     = (cur == ST_EHALT) ? ST_ESNOOP : ST_SNOOP;
      ret_we  = 1'b1;
      pend_we = 1'b1;
      pend_d  = wake_evt && is_halt(cur);
    end else begin
      case (cur)
        ST_RUN: begin
          if (stpgnt_req)    nxt = ST_STPGNT;
          else if (halt_req) nxt = ehalt_en ? ST_EHALT : ST_HALT;
        end
        ST_HALT, ST_EHALT: begin
          if (wake_evt) nxt = ST_RUN;
        end
        ST_STPGNT: begin
          if (!stpgnt_req) nxt = ST_RUN;
        end
        ST_SNOOP, ST_ESNOOP: begin
          pend_we = 1'b1;
          if (snoop_done) begin
            nxt    = owed ? ST_RUN : ret_q;
            pend_d = 1'b0;
          end else begin
            pend_d = owed;
          end
        end
        default: nxt = ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/isc_track.sv
module isc_track
  import isc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ret_we,
  input  pstate_e ret_d,
  input  logic    pend_we,
  input  logic    pend_d,
  output pstate_e ret_q,
  output logic    pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_q <= ST_HALT;
    else if (ret_we) ret_q <= ret_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_we) pend_q <= pend_d;
  end
endmodule

// File: rtl/isc_outdec.sv
module isc_outdec
  import isc_pkg::*;
(
  input  pstate_e cur,
  output logic    snoop_clk_en,
  output logic    low_op_req
);
  assign snoop_clk_en = is_snoop(cur);
  assign low_op_req   = (cur == ST_EHALT) || (cur == ST_ESNOOP);
endmodule

// File: rtl/idle_snoop_ctrl.sv
module idle_snoop_ctrl
  import isc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_req,
  input  logic               stpgnt_req,
  input  logic               ehalt_en,
  input  logic               wake_evt,
  input  logic               snoop_start,
  input  logic               snoop_done,
  output logic [STATE_W-1:0] state_o,
  output logic               snoop_clk_en,
  output logic               low_op_req
);
  pstate_e state_q;
  pstate_e state_d;
  pstate_e ret_q;
  logic    pend_q;
  logic    ret_we;
  logic    pend_we;
  logic    pend_d;

  isc_next u_next (
    .cur         (state_q),
    .ret_q       (ret_q),
    .pend_q      (pend_q),
    .halt_req    (halt_req),
    .stpgnt_req  (stpgnt_req),
    .ehalt_en    (ehalt_en),
    .wake_evt    (wake_evt),
    .snoop_start (snoop_start),
    .snoop_done  (snoop_done),
    .nxt         (state_d),
    .ret_we      (ret_we),
    .pend_we     (pend_we),
    .pend_d      (pend_d)
  );

  isc_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .ret_we  (ret_we),
    .ret_d   (state_q),
    .pend_we (pend_we),
    .pend_d  (pend_d),
    .ret_q   (ret_q),
    .pend_q  (pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  isc_outdec u_out (
    .cur          (state_q),
    .snoop_clk_en (snoop_clk_en),
    .low_op_req   (low_op_req)
  );

  assign state_o = state_q;
endmodule

// File: rtl/idle_snoop_ctrl_chk.sv
module idle_snoop_ctrl_chk
  import isc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               stpgnt_req,
  input logic               wake_evt,
  input logic               snoop_start,
  input logic               snoop_done,
  input logic [STATE_W-1:0] state_o,
  input logic               snoop_clk_en,
  input logic               low_op_req
);
  a_r4_snoop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o >= 3'd4 && !snoop_done) |=> $stable(state_o));

  a_r3_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_start && (state_o == 3'd1 || state_o == 3'd3)) |=> (state_o == 3'd4));

  a_r3_ehalt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_start && state_o == 3'd2) |=> (state_o == 3'd5));

  a_r5_esnoop_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && snoop_done) |=> (state_o == 3'd2 || state_o == 3'd0));

  a_r10_stpgnt_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && !stpgnt_req && !snoop_start) |=> (state_o == 3'd0));

  a_r7_clk_en_match: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_clk_en == (state_o == 3'd4 || state_o == 3'd5));

  a_r6_low_op_match: assert property (@(posedge clk) disable iff (!rst_n)
    low_op_req == (state_o == 3'd2 || state_o == 3'd5));

  a_r8_halt_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && wake_evt && !snoop_start) |=> (state_o == 3'd0));

  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5);
endmodule

bind idle_snoop_ctrl idle_snoop_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stpgnt_req   (stpgnt_req),
  .wake_evt     (wake_evt),
  .snoop_start  (snoop_start),
  .snoop_done   (snoop_done),
  .state_o      (state_o),
  .snoop_clk_en (snoop_clk_en),
  .low_op_req   (low_op_req)
);

// File: tb/tb_idle_snoop_ctrl.sv
module tb_idle_snoop_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       halt_req, stpgnt_req, ehalt_en, wake_evt, snoop_start, snoop_done;
  logic [2:0] state_o;
  logic       snoop_clk_en, low_op_req;
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done_f = 1'b0;

  always #5 clk = ~clk;

  idle_snoop_ctrl dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stpgnt_req(stpgnt_req),
    .ehalt_en(ehalt_en), .wake_evt(wake_evt), .snoop_start(snoop_start),
    .snoop_done(snoop_done), .state_o(state_o), .snoop_clk_en(snoop_clk_en),
    .low_op_req(low_op_req)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // State plus both output requests, expected derived from the state code
  task automatic chk_st(string req, int exp);
    chk(req, state_o, exp);
    chk({req, "/R7"}, snoop_clk_en, (exp == 4 || exp == 5) ? 1 : 0);
    chk({req, "/R6"}, low_op_req,   (exp == 2 || exp == 5) ? 1 : 0);
  endtask

  task automatic idle_inputs();
    halt_req = 0; stpgnt_req = 0; ehalt_en = 0;
    wake_evt = 0; snoop_start = 0; snoop_done = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    tick();
    chk_st("R1 in reset", 0);
    rst_n = 1;
    tick();
    chk_st("R1 after reset", 0);
  endtask

  initial begin
    do_reset();

    // R3: snoop strobe in running is ignored
    snoop_start = 1; snoop_done = 1; wake_evt = 1;
    tick();
    idle_inputs();
    chk_st("R3 snoop in running", 0);

    // R2: stop-grant wins over halt
    stpgnt_req = 1; halt_req = 1; ehalt_en = 1;
    tick();
    halt_req = 0;
    chk_st("R2 stpgnt priority", 3);
    stpgnt_req = 0;
    tick();
    chk_st("R10 stpgnt release", 0);

    // Sweep: origin x wake timing x snoop length
    for (int org = 0; org < 3; org++) begin
      for (int wm = 0; wm < 4; wm++) begin
        for (int len = 0; len < 3; len++) begin
          int ost;
          int sst;
          int fin;
          ost = (org == 0) ? 1 : (org == 1) ? 2 : 3;
          sst = (org == 1) ? 5 : 4;
          fin = (org != 2 && wm != 0) ? 0 : ost;
          do_reset();
          ehalt_en = (org == 1);
          if (org == 2) stpgnt_req = 1; else halt_req = 1;
          tick();
          halt_req = 0;
          chk_st("R2 idle entry", ost);
          tick();
          chk_st("R2 idle hold", ost);
          snoop_start = 1; wake_evt = (wm == 3);
          tick();
          snoop_start = 0; wake_evt = 0;
          chk_st("R3 snoop entry", sst);
          for (int k = 0; k < len; k++) begin
            wake_evt = (wm == 1 && k == 0);
            tick();
            wake_evt = 0;
            chk_st("R4 snoop hold", sst);
          end
          if (wm == 1 && len == 0) wake_evt = 1;
          snoop_done = 1;
          if (wm == 2) wake_evt = 1;
          tick();
          snoop_done = 0; wake_evt = 0;
          chk_st((fin == 0) ? "R9 owed wake" : "R5 return", fin);
          if (fin != 0) begin
            if (org == 2) begin
              wake_evt = 1;
              tick();
              wake_evt = 0;
              chk_st("R9 wake ignored in stpgnt", 3);
              stpgnt_req = 0;
              tick();
              chk_st("R10 stpgnt release", 0);
            end else begin
              wake_evt = 1;
              tick();
              wake_evt = 0;
              chk_st("R8 wake from halt", 0);
            end
          end
        end
      end
    end

    done_f = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_f) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule